// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses, for a conditional branch at a given fetch address, whether it will be taken. It holds two predictors and a third that picks between them. The local predictor is two-level. A per-branch history table, addressed by fetch-address bits, keeps each branch's recent outcomes. That history then addresses a table of 3-bit saturating counters. The global predictor is a table of 2-bit counters addressed by a shift register of the most recent resolved outcomes. A choice table of 2-bit counters, addressed by the same global history, decides which of the two guesses is returned.

A lookup presents a fetch address. One cycle later the block returns the prediction and a snapshot: the local-history index, the local history read, the global history used, and the two component guesses. When the branch resolves, the pipeline returns that snapshot with the real outcome on the update port. The block then trains all three tables and shifts the branch's local history and the global history.

A flush, or reset, restarts the clearing walk. The walk puts every table back to its starting value, one entry per cycle. The controller has two states. ST_SWEEP walks the clear pointer. ST_RUN predicts and trains. ST_SWEEP goes to ST_RUN on transition T_DONE, once the last entry is written. Any state goes to ST_SWEEP at entry 0 on transition T_RESTART, taken on flush. Reset enters ST_SWEEP at entry 0.

Top module: `tournament_predictor`

## Requirements
- R1: A lookup with `lk_valid` high in cycle t gives `pred_valid` high in cycle t+1. With `lk_valid` low, cycle t+1 has `pred_valid` and `pred_taken` low.
- R2: The local-history index is fetch-address bits [11:2], `lk_pc[PC_LSB +: 10]`. It is returned on `pred_lidx`.
- R3: Local pattern counters are 3 bits wide, addressed by the 10-bit local history. They predict taken when bit 2 is set. Training moves them by one toward the outcome, and they saturate at 0 and 7.
- R4: Global counters are 2 bits wide, addressed by the 12-bit global history. They predict taken when bit 1 is set, and they saturate at 0 and 3.
- R5: In the global history, bit i is 1 when the i-th prior accepted update was taken. Each accepted update shifts the register left and puts the outcome into bit 0. The value used by a lookup is returned on `pred_ghist`.
- R6: The choice counter sits at the global-history address. A value of 2 or more returns the global guess; otherwise the local guess is returned.
- R7: The choice counter is trained only when the snapshot's local and global guesses differ. It moves up when the global guess matched the outcome and down otherwise, saturating at 0 and 3.
- R8: An accepted update shifts the local-history entry at `upd_lidx` left and puts the outcome into bit 0. `pred_lhist` returns the entry that a lookup read.
- R9: Flush or reset enters the clearing walk for 4096 cycles. During the walk, predictions are not-taken, updates are ignored and the global history is zero. An update in the flush cycle itself is ignored.
- R10: After the walk, all histories are zero, pattern and global counters are weakly not-taken (3 and 1), and choice counters are weakly local (1).
- R11: A lookup in the same cycle as an update reads the table state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Clears all tables and history |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Fetch address of the lookup |
| pred_valid | output | 1 | Prediction present |
| pred_taken | output | 1 | Predicted direction |
| pred_lidx | output | LH_IDX_W | Snapshot: local-history index |
| pred_lhist | output | LH_W | Snapshot: local history read |
| pred_ghist | output | GH_W | Snapshot: global history used |
| pred_local | output | 1 | Snapshot: local guess |
| pred_global | output | 1 | Snapshot: global guess |
| upd_valid | input | 1 | Resolved-branch update |
| upd_taken | input | 1 | Resolved outcome |
| upd_lidx | input | LH_IDX_W | Returned local-history index |
| upd_lhist | input | LH_W | Returned local history |
| upd_ghist | input | GH_W | Returned global history |
| upd_local | input | 1 | Returned local guess |
| upd_global | input | 1 | Returned global guess |

## Verification
Every prediction and snapshot field is due one clock after its lookup. The training from an update is first visible to a lookup in the cycle after the update. The bench's behavioural model steps at each rising edge. It computes the expected outputs from its state before it applies that edge's update or flush. The outputs are compared at the following falling edge. Fields of the snapshot are compared only when the model is out of the clearing walk, and the walk is counted as exactly 4096 edges after a flush or reset.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } tbp_state_e;

    function automatic int unsigned tbp_max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tbp_sweep_fsm.sv
module tbp_sweep_fsm
    import tbp_pkg::*;
#(
    parameter int unsigned SWEEP_N = 4096,
    localparam int unsigned CNT_W  = $clog2(SWEEP_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    output logic             sweeping,
    output logic [CNT_W-1:0] sweep_idx
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SWEEP_N - 1);

    tbp_state_e       state_q, state_d;
    logic [CNT_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state: T_RESTART on flush, T_DONE at the last entry
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (flush) begin
            state_d = ST_SWEEP;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_SWEEP: begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_RUN;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + CNT_W'(1);
                    end
                end
                ST_RUN: begin
                    state_d = ST_RUN;
                end
                default: begin
                    state_d = ST_SWEEP;
                    idx_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sweeping  = (state_q == ST_SWEEP);
        sweep_idx = idx_q;
    end

    AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (sweeping && sweep_idx == '0)); // R9

    AST_SWEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && !flush && sweep_idx != LAST_IDX) |=> sweeping); // R9

endmodule

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
    parameter int unsigned ENTRIES = 4096,
    parameter int unsigned CTR_W   = 2,
    parameter int unsigned INIT    = 1,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             trn_en,
    input  logic [IDX_W-1:0] trn_idx,
    input  logic             trn_up
);

    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(INIT);

    logic [CTR_W-1:0] mem [ENTRIES];
    logic [CTR_W-1:0] trn_cur, trn_nxt;

    assign rd_ctr  = mem[rd_idx];
    assign trn_cur = mem[trn_idx];

    always_comb begin
        trn_nxt = trn_cur;
        if (trn_up && trn_cur != CTR_MAX)
            trn_nxt = trn_cur + CTR_W'(1);
        else if (!trn_up && trn_cur != '0)
            trn_nxt = trn_cur - CTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (clr_en)
            mem[clr_idx] <= CTR_INIT;
        else if (trn_en)
            mem[trn_idx] <= trn_nxt;
    end

    AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_en && !clr_en && trn_up && trn_cur == CTR_MAX) |=> (mem[$past(trn_idx)] == CTR_MAX)); // R3

    AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_en && !clr_en && !trn_up && trn_cur == '0) |=> (mem[$past(trn_idx)] == '0)); // R4

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned HIST_W  = 10,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              sh_en,
    input  logic [IDX_W-1:0]  sh_idx,
    input  logic              sh_bit
);

    logic [HIST_W-1:0] mem [ENTRIES];
    logic [HIST_W-1:0] sh_cur;

    assign rd_hist = mem[rd_idx];
    assign sh_cur  = mem[sh_idx];

    always_ff @(posedge clk) begin
        if (clr_en)
            mem[clr_idx] <= '0;
        else if (sh_en)
            mem[sh_idx] <= {sh_cur[HIST_W-2:0], sh_bit};
    end

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tbp_pkg::*;
#(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned PC_LSB   = 2,
    parameter int unsigned LH_IDX_W = 10,
    parameter int unsigned LH_W     = 10,
    parameter int unsigned LP_CTR_W = 3,
    parameter int unsigned GH_W     = 12,
    parameter int unsigned G_CTR_W  = 2,
    parameter int unsigned C_CTR_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                lk_valid,
    input  logic [PC_W-1:0]     lk_pc,
    output logic                pred_valid,
    output logic                pred_taken,
    output logic [LH_IDX_W-1:0] pred_lidx,
    output logic [LH_W-1:0]     pred_lhist,
    output logic [GH_W-1:0]     pred_ghist,
    output logic                pred_local,
    output logic                pred_global,
    input  logic                upd_valid,
    input  logic                upd_taken,
    input  logic [LH_IDX_W-1:0] upd_lidx,
    input  logic [LH_W-1:0]     upd_lhist,
    input  logic [GH_W-1:0]     upd_ghist,
    input  logic                upd_local,
    input  logic                upd_global
);

    localparam int unsigned LH_N    = 1 << LH_IDX_W;
    localparam int unsigned LP_N    = 1 << LH_W;
    localparam int unsigned G_N     = 1 << GH_W;
    localparam int unsigned SWEEP_N = tbp_max3(LH_N, LP_N, G_N);
    localparam int unsigned CNT_W   = $clog2(SWEEP_N);
    localparam int unsigned LP_INIT = (1 << (LP_CTR_W - 1)) - 1;
    localparam int unsigned G_INIT  = (1 << (G_CTR_W - 1)) - 1;
    localparam int unsigned C_INIT  = (1 << (C_CTR_W - 1)) - 1;

    logic                sweeping;
    logic [CNT_W-1:0]    sweep_idx;
    logic [GH_W-1:0]     ghr_q;
    logic [LH_IDX_W-1:0] lk_lidx;
    logic [LH_W-1:0]     lk_lhist;
    logic [LP_CTR_W-1:0] lp_ctr;
    logic [G_CTR_W-1:0]  g_ctr;
    logic [C_CTR_W-1:0]  c_ctr;
    logic                guess_local, guess_global, use_global, upd_acc;
    logic                unused_pc_bits;

    assign lk_lidx        = lk_pc[PC_LSB +: LH_IDX_W];
    assign unused_pc_bits = ^{lk_pc[PC_W-1:PC_LSB+LH_IDX_W], lk_pc[PC_LSB-1:0]};
    assign upd_acc        = upd_valid && !sweeping && !flush;

    tbp_sweep_fsm #(.SWEEP_N(SWEEP_N)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .sweeping (sweeping),
        .sweep_idx(sweep_idx)
    );

    tbp_hist_table #(.ENTRIES(LH_N), .HIST_W(LH_W)) u_lhist (
        .clk    (clk),
        .rd_idx (lk_lidx),
        .rd_hist(lk_lhist),
        .clr_en (sweeping),
        .clr_idx(sweep_idx[LH_IDX_W-1:0]),
        .sh_en  (upd_acc),
        .sh_idx (upd_lidx),
        .sh_bit (upd_taken)
    );

    tbp_ctr_table #(.ENTRIES(LP_N), .CTR_W(LP_CTR_W), .INIT(LP_INIT)) u_lpat (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_lhist),
        .rd_ctr (lp_ctr),
        .clr_en (sweeping),
        .clr_idx(sweep_idx[LH_W-1:0]),
        .trn_en (upd_acc),
        .trn_idx(upd_lhist),
        .trn_up (upd_taken)
    );

    tbp_ctr_table #(.ENTRIES(G_N), .CTR_W(G_CTR_W), .INIT(G_INIT)) u_gpat (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghr_q),
        .rd_ctr (g_ctr),
        .clr_en (sweeping),
        .clr_idx(sweep_idx[GH_W-1:0]),
        .trn_en (upd_acc),
        .trn_idx(upd_ghist),
        .trn_up (upd_taken)
    );

    tbp_ctr_table #(.ENTRIES(G_N), .CTR_W(C_CTR_W), .INIT(C_INIT)) u_choice (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghr_q),
        .rd_ctr (c_ctr),
        .clr_en (sweeping),
        .clr_idx(sweep_idx[GH_W-1:0]),
        .trn_en (upd_acc && (upd_local != upd_global)),
        .trn_idx(upd_ghist),
        .trn_up (upd_global == upd_taken)
    );

    assign guess_local  = lp_ctr[LP_CTR_W-1];
    assign guess_global = g_ctr[G_CTR_W-1];
    assign use_global   = c_ctr[C_CTR_W-1];

    // global history register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ghr_q <= '0;
        else if (flush || sweeping)
            ghr_q <= '0;
        else if (upd_acc)
            ghr_q <= {ghr_q[GH_W-2:0], upd_taken};
    end

    // prediction outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_valid  <= 1'b0;
            pred_taken  <= 1'b0;
            pred_lidx   <= '0;
            pred_lhist  <= '0;
            pred_ghist  <= '0;
            pred_local  <= 1'b0;
            pred_global <= 1'b0;
        end else begin
            pred_valid  <= lk_valid;
            pred_taken  <= lk_valid && !sweeping && (use_global ? guess_global : guess_local);
            pred_lidx   <= lk_lidx;
            pred_lhist  <= lk_lhist;
            pred_ghist  <= ghr_q;
            pred_local  <= guess_local;
            pred_global <= guess_global;
        end
    end

    AST_PRED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pred_valid); // R1

    AST_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!pred_valid && !pred_taken)); // R1

    AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_acc |=> (ghr_q[0] == $past(upd_taken) && ghr_q[GH_W-1:1] == $past(ghr_q[GH_W-2:0]))); // R5

    AST_GHR_ZERO_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |-> (ghr_q == '0)); // R9

    AST_SWEEP_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && lk_valid) |=> !pred_taken); // R9

    AST_CHOICE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_acc && upd_local == upd_global) |=>
            (u_choice.mem[$past(upd_ghist)] == $past(u_choice.mem[upd_ghist]))); // R7

endmodule

// File: tb/tournament_predictor_tb.sv
`timescale 1ns/1ps
module tournament_predictor_tb;

    localparam int SWEEP = 4096;

    logic        clk, rst_n, flush, lk_valid;
    logic [31:0] lk_pc;
    logic        pred_valid, pred_taken, pred_local, pred_global;
    logic [9:0]  pred_lidx, pred_lhist;
    logic [11:0] pred_ghist;
    logic        upd_valid, upd_taken, upd_local, upd_global;
    logic [9:0]  upd_lidx, upd_lhist;
    logic [11:0] upd_ghist;

    tournament_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_lidx(pred_lidx),
        .pred_lhist(pred_lhist), .pred_ghist(pred_ghist), .pred_local(pred_local),
        .pred_global(pred_global), .upd_valid(upd_valid), .upd_taken(upd_taken),
        .upd_lidx(upd_lidx), .upd_lhist(upd_lhist), .upd_ghist(upd_ghist),
        .upd_local(upd_local), .upd_global(upd_global)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // behavioural model state
    int lht [1024];
    int lpt [1024];
    int gpt [4096];
    int cht [4096];
    int ghr, sweep_left, iter;
    bit exp_valid, exp_taken, exp_run, exp_lp, exp_gp;
    int exp_lidx, exp_lh, exp_gh;
    int checks, errors;
    bit done;
    int iq_out[$];
    int uq_lidx[$], uq_lh[$], uq_gh[$], uq_lp[$], uq_gp[$], uq_out[$];

    function automatic void model_clear();
        foreach (lht[i]) lht[i] = 0;
        foreach (lpt[i]) lpt[i] = 3;
        foreach (gpt[i]) gpt[i] = 1;
        foreach (cht[i]) cht[i] = 1;
        ghr = 0;
    endfunction

    function automatic int sat(int v, bit up, int mx);
        if (up) return (v < mx) ? v + 1 : mx;
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            model_clear();
            sweep_left = SWEEP;
            exp_valid = 0; exp_taken = 0; exp_run = 0;
            return;
        end
        exp_run   = (sweep_left == 0);
        exp_valid = lk_valid;
        exp_lidx  = int'((lk_pc >> 2) & 32'h3ff);
        exp_lh    = lht[exp_lidx];
        exp_gh    = ghr;
        exp_lp    = (lpt[exp_lh] >= 4);
        exp_gp    = (gpt[ghr] >= 2);
        exp_taken = lk_valid && exp_run && ((cht[ghr] >= 2) ? exp_gp : exp_lp);
        if (flush) begin
            model_clear();
            sweep_left = SWEEP;
        end else if (!exp_run) begin
            sweep_left--;
        end else if (upd_valid) begin
            lpt[upd_lhist] = sat(lpt[upd_lhist], upd_taken, 7);
            gpt[upd_ghist] = sat(gpt[upd_ghist], upd_taken, 3);
            if (upd_local != upd_global)
                cht[upd_ghist] = sat(cht[upd_ghist], upd_global == upd_taken, 3);
            lht[upd_lidx] = ((lht[upd_lidx] << 1) | int'(upd_taken)) & 32'h3ff;
            ghr = ((ghr << 1) | int'(upd_taken)) & 32'hfff;
        end
    endtask

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic compare();
        chk(pred_valid == exp_valid, "R1 pred_valid", int'(pred_valid), int'(exp_valid));
        if (exp_valid && !exp_run)
            chk(pred_taken == 1'b0, "R9 pred_taken in clearing walk", int'(pred_taken), 0);
        if (exp_valid && exp_run) begin
            chk(pred_taken == exp_taken, "R6 R7 R11 pred_taken", int'(pred_taken), int'(exp_taken));
            chk(int'(pred_lidx) == exp_lidx, "R2 pred_lidx", int'(pred_lidx), exp_lidx);
            chk(int'(pred_lhist) == exp_lh, "R8 pred_lhist", int'(pred_lhist), exp_lh);
            chk(int'(pred_ghist) == exp_gh, "R5 pred_ghist", int'(pred_ghist), exp_gh);
            chk(pred_local == exp_lp, "R3 pred_local", int'(pred_local), int'(exp_lp));
            chk(pred_global == exp_gp, "R4 pred_global", int'(pred_global), int'(exp_gp));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    // drive one cycle's inputs (called at a falling edge, after compare)
    task automatic drive(int mode, bit junk);
        int o;
        o = 0;
        if (exp_valid) begin
            o = iq_out.pop_front();
            if (exp_run) begin
                uq_lidx.push_back(exp_lidx); uq_lh.push_back(exp_lh); uq_gh.push_back(exp_gh);
                uq_lp.push_back(int'(exp_lp)); uq_gp.push_back(int'(exp_gp)); uq_out.push_back(o);
            end
        end
        iter++;
        lk_valid = 1'b1;
        case (mode)
            0: begin lk_pc = 32'h100; o = 1; end
            1: begin lk_pc = 32'h204; o = iter % 2; end
            3: begin lk_pc = 32'h400 + 32'((iter % 4) * 4); o = ((iter % 4) == 1 || (iter % 4) == 2) ? 1 : 0; end
            default: begin
                lk_pc = $urandom & 32'hffc;
                o = int'($urandom_range(0, 1));
                lk_valid = ($urandom_range(0, 9) < 8);
            end
        endcase
        if (lk_valid) iq_out.push_back(o);
        if (junk) begin
            upd_valid = 1'b1; upd_taken = 1'b1;
            upd_lidx = 10'($urandom); upd_lhist = 10'($urandom); upd_ghist = 12'($urandom);
            upd_local = 1'b0; upd_global = 1'b1;
        end else if (uq_out.size() >= 2) begin
            upd_valid  = 1'b1;
            upd_lidx   = 10'(uq_lidx.pop_front());
            upd_lhist  = 10'(uq_lh.pop_front());
            upd_ghist  = 12'(uq_gh.pop_front());
            upd_local  = uq_lp.pop_front() != 0;
            upd_global = uq_gp.pop_front() != 0;
            upd_taken  = uq_out.pop_front() != 0;
        end else begin
            upd_valid = 1'b0;
        end
    endtask

    task automatic run_phase(int mode, int n);
        for (int k = 0; k < n; k++) begin
            drive(mode, 1'b0);
            tick();
        end
    endtask

    task automatic wait_sweep();
        while (sweep_left > 0) begin
            drive(2, 1'b1);
            tick();
        end
    endtask

    task automatic fresh_lookup_check();
        // R10: first lookup after the walk sees the starting state
        drive(0, 1'b0);
        upd_valid = 1'b0;
        lk_valid = 1'b1; lk_pc = 32'h300;
        tick();
        chk(pred_taken == 1'b0, "R10 taken after clear", int'(pred_taken), 0);
        chk(pred_ghist == 12'd0 && pred_lhist == 10'd0, "R10 histories after clear",
            int'(pred_ghist) + int'(pred_lhist), 0);
        chk(pred_local == 1'b0 && pred_global == 1'b0, "R10 counters after clear",
            int'(pred_local) + int'(pred_global), 0);
    endtask

    initial begin
        checks = 0; errors = 0; done = 0; iter = 0;
        rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_pc = '0;
        upd_valid = 1'b0; upd_taken = 1'b0; upd_lidx = '0; upd_lhist = '0;
        upd_ghist = '0; upd_local = 1'b0; upd_global = 1'b0;
        model_clear();
        sweep_left = SWEEP;
        for (int k = 0; k < 3; k++) tick();
        chk(pred_valid == 1'b0 && pred_taken == 1'b0, "R9 reset outputs", int'(pred_valid), 0);
        rst_n = 1'b1;
        wait_sweep();
        fresh_lookup_check();
        run_phase(0, 300);
        run_phase(1, 400);
        run_phase(3, 400);
        run_phase(2, 2000);
        // flush with a simultaneous update: the update must be dropped (R9)
        drive(2, 1'b1);
        flush = 1'b1;
        tick();
        flush = 1'b0;
        wait_sweep();
        fresh_lookup_check();
        run_phase(3, 300);
        run_phase(2, 1000);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule